// File: doc/BRIEF.md
# Layer-Step Sequencer for a Memory-Array Matrix Multiplier

This controller sequences one matrix-vector multiply over an array of processing elements that store weights in stacked memory layers. When an operation is accepted, it latches which rows and columns of processing elements take part. It drives those enables for the whole operation. For each layer step it then runs a fixed order:

1. Fetch the input vector and select the weight layer, both at once.
2. Apply the time-coded inputs with the elements in operation mode.
3. Switch to the sweep layer and wait for the output conversion.
4. Pass the result to a writeback agent.

Every stage is a request held until the owning agent returns a one-cycle done pulse.

A kernel larger than one array pass spans several consecutive layers. The operation carries a base layer and a step count. Each writeback is tagged with its layer and with a flag on the final step, which tells the downstream accumulator when to finish its sum. Writeback runs in the background. While the collector still stores step n, the controller already fetches inputs and computes step n+1, or accepts the next operation. The result of a step is only handed over once the previous writeback has completed.

Top module: `vmm_step_ctrl`

## Requirements
- R1: `op_ready` is high exactly when the controller is idle. An `op_start` seen with `op_ready` high latches `op_rows`, `op_cols`, `op_base` and `op_nlm1`. From the next cycle until the operation's last step is handed to writeback, `row_en`/`col_en` equal the latched masks; while idle they are zero.
- R2: The cycle after acceptance is an enable-only cycle, with no `ld_req` and no `sel_req`. On the cycle after that, `ld_req` and `sel_req` rise together.
- R3: `ld_req` and `sel_req` are each held until their own done pulse, which may come in either order. Phase I never starts before both have completed.
- R4: `vmm_op` is high exactly while `ph1_req` is held, and `ph1_req` is held until `ph1_done`. `sweep_sel` is low throughout.
- R5: After `ph1_done`, `sweep_sel` and `conv_req` are high, with `vmm_op` low, until `conv_done`.
- R6: After conversion the result is handed over by raising `wb_req`, with `wb_layer` (the step's layer) and `wb_last` (1 only on the final step). All three are held unchanged until `wb_done`.
- R7: When more steps remain, the next step's `ld_req` and `sel_req` rise the cycle after handoff, even if that writeback is still pending.
- R8: A new handoff never occurs while `wb_req` is high. `wb_req` is low for at least one cycle after each `wb_done`, and no writeback result is lost or overwritten.
- R9: An operation performs `op_nlm1`+1 steps. Step s uses layer `op_base`+s (modulo the layer width) on `layer_idx`, and produces exactly one writeback carrying that layer, in order.
- R10: After the final handoff the controller returns to idle at once, so a new operation can be accepted while the last writeback is still outstanding.
- R11: After reset the controller is idle with every request, enable and mode output low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| op_start | input | 1 | Start an operation (taken when op_ready) |
| op_rows | input | ROWS | Row enable mask for the operation |
| op_cols | input | COLS | Column enable mask for the operation |
| op_base | input | LAYER_W | First weight layer |
| op_nlm1 | input | LAYER_W | Number of layer steps minus one |
| op_ready | output | 1 | Idle, can accept op_start |
| row_en | output | ROWS | Row select to processing elements |
| col_en | output | COLS | Column select to elements, converters and output units |
| ld_req | output | 1 | Input buffer load request |
| ld_done | input | 1 | Load complete pulse |
| sel_req | output | 1 | Weight layer select request |
| layer_idx | output | LAYER_W | Layer selected for the current step |
| sel_done | input | 1 | Layer select complete pulse |
| vmm_op | output | 1 | Elements in operation mode |
| ph1_req | output | 1 | Apply phase I inputs |
| ph1_done | input | 1 | Phase I complete pulse |
| sweep_sel | output | 1 | Sweep layer selected |
| conv_req | output | 1 | Output conversion request |
| conv_done | input | 1 | Conversion complete pulse |
| wb_req | output | 1 | Writeback request to collector |
| wb_last | output | 1 | Writeback belongs to the final step |
| wb_layer | output | LAYER_W | Layer of the result being written back |
| wb_done | input | 1 | Writeback complete pulse |

## Verification
The bench targets three corner cases:

- **Slow writeback against fast compute.** A design that overwrote a pending handoff would drop or reorder layer tags, and the scoreboard at the collector would catch it. A design that stalled would lose the load overlap.
- **Done pulses in both orders, and at zero delay.** A controller that started phase I on only one of the two completions would raise `ph1_req` before the bench saw both.
- **A back-to-back operation issued while the last writeback is open.** A design that waited for writeback before going idle would fail that acceptance. A design that mis-flagged the final step would send the wrong `wb_last`.

// File: rtl/vmm_step_ctrl.sv
module vmm_step_ctrl #(
  parameter int ROWS    = 4,
  parameter int COLS    = 8,
  parameter int LAYER_W = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               op_start,
  input  logic [ROWS-1:0]    op_rows,
  input  logic [COLS-1:0]    op_cols,
  input  logic [LAYER_W-1:0] op_base,
  input  logic [LAYER_W-1:0] op_nlm1,
  output logic               op_ready,
  output logic [ROWS-1:0]    row_en,
  output logic [COLS-1:0]    col_en,
  output logic               ld_req,
  input  logic               ld_done,
  output logic               sel_req,
  output logic [LAYER_W-1:0] layer_idx,
  input  logic               sel_done,
  output logic               vmm_op,
  output logic               ph1_req,
  input  logic               ph1_done,
  output logic               sweep_sel,
  output logic               conv_req,
  input  logic               conv_done,
  output logic               wb_req,
  output logic               wb_last,
  output logic [LAYER_W-1:0] wb_layer,
  input  logic               wb_done
);

  typedef enum logic [2:0] {S_IDLE, S_ENA, S_LS, S_PH1, S_CONV, S_HAND} st_t;

  st_t                st;
  logic [ROWS-1:0]    rows_q;
  logic [COLS-1:0]    cols_q;
  logic [LAYER_W-1:0] base_q, last_q, step_q;
  logic               ld_ok, sel_ok;

  wire is_last = (step_q == last_q);
  wire ls_go   = (ld_ok | ld_done) & (sel_ok | sel_done);
  wire hand    = (st == S_HAND) & ~wb_req;
  wire active  = (st != S_IDLE);

  assign op_ready  = (st == S_IDLE);
  assign row_en    = active ? rows_q : '0;
  assign col_en    = active ? cols_q : '0;
  assign ld_req    = (st == S_LS) & ~ld_ok;
  assign sel_req   = (st == S_LS) & ~sel_ok;
  assign layer_idx = base_q + step_q;
  assign ph1_req   = (st == S_PH1);
  assign vmm_op    = (st == S_PH1);
  assign conv_req  = (st == S_CONV);
  assign sweep_sel = (st == S_CONV);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      rows_q <= '0;
      cols_q <= '0;
      base_q <= '0;
      last_q <= '0;
      step_q <= '0;
      ld_ok  <= 1'b0;
      sel_ok <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (op_start) begin
          rows_q <= op_rows;
          cols_q <= op_cols;
          base_q <= op_base;
          last_q <= op_nlm1;
          step_q <= '0;
          st     <= S_ENA;
        end
        S_ENA: st <= S_LS;
        S_LS: begin
          if (ls_go) begin
            ld_ok  <= 1'b0;
            sel_ok <= 1'b0;
            st     <= S_PH1;
          end else begin
            ld_ok  <= ld_ok | ld_done;
            sel_ok <= sel_ok | sel_done;
          end
        end
        S_PH1:  if (ph1_done) st <= S_CONV;
        S_CONV: if (conv_done) st <= S_HAND;
        S_HAND: if (hand) begin
          if (is_last) st <= S_IDLE;
          else begin
            step_q <= step_q + 1'b1;
            st     <= S_LS;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wb_req   <= 1'b0;
      wb_last  <= 1'b0;
      wb_layer <= '0;
    end else if (hand) begin
      wb_req   <= 1'b1;
      wb_last  <= is_last;
      wb_layer <= layer_idx;
    end else if (wb_done) begin
      wb_req   <= 1'b0;
    end
  end

endmodule

// File: rtl/vmm_step_ctrl_chk.sv
module vmm_step_ctrl_chk #(
  parameter int ROWS    = 4,
  parameter int COLS    = 8,
  parameter int LAYER_W = 6
) (
  input logic               clk,
  input logic               rst_n,
  input logic               op_start,
  input logic [ROWS-1:0]    op_rows,
  input logic [COLS-1:0]    op_cols,
  input logic [LAYER_W-1:0] op_base,
  input logic [LAYER_W-1:0] op_nlm1,
  input logic               op_ready,
  input logic [ROWS-1:0]    row_en,
  input logic [COLS-1:0]    col_en,
  input logic               ld_req,
  input logic               ld_done,
  input logic               sel_req,
  input logic [LAYER_W-1:0] layer_idx,
  input logic               sel_done,
  input logic               vmm_op,
  input logic               ph1_req,
  input logic               ph1_done,
  input logic               sweep_sel,
  input logic               conv_req,
  input logic               conv_done,
  input logic               wb_req,
  input logic               wb_last,
  input logic [LAYER_W-1:0] wb_layer,
  input logic               wb_done
);

  AST_IDLE_NO_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    op_ready |-> (row_en == '0 && col_en == '0)); // R1
  AST_ACCEPT_ENABLE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (op_ready && op_start) |=> (!ld_req && !sel_req && !op_ready)); // R2
  AST_LOAD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_req && !ld_done) |=> ld_req); // R3
  AST_SELECT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_req && !sel_done) |=> sel_req); // R3
  AST_PH1_AFTER_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
    ph1_req |-> (!ld_req && !sel_req && vmm_op && !sweep_sel)); // R4
  AST_CONV_ON_SWEEP: assert property (@(posedge clk) disable iff (!rst_n)
    conv_req |-> (sweep_sel && !vmm_op && !ph1_req)); // R5
  AST_WB_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_req && !wb_done) |=> (wb_req && $stable(wb_layer) && $stable(wb_last))); // R6
  AST_WB_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_req && wb_done) |=> !wb_req); // R8

endmodule

bind vmm_step_ctrl vmm_step_ctrl_chk #(.ROWS(ROWS), .COLS(COLS), .LAYER_W(LAYER_W)) u_chk (.*);

// File: tb/vmm_step_ctrl_bench.sv
module vmm_step_ctrl_bench;
  localparam int ROWS = 4, COLS = 8, LW = 6;

  logic clk = 0, rst_n = 0;
  logic op_start = 0;
  logic [ROWS-1:0] op_rows = '0;
  logic [COLS-1:0] op_cols = '0;
  logic [LW-1:0] op_base = '0, op_nlm1 = '0;
  logic op_ready, ld_req, sel_req, vmm_op, ph1_req, sweep_sel, conv_req, wb_req, wb_last;
  logic [ROWS-1:0] row_en;
  logic [COLS-1:0] col_en;
  logic [LW-1:0] layer_idx, wb_layer;
  logic ld_done = 0, sel_done = 0, ph1_done = 0, conv_done = 0, wb_done = 0;

  int ld_dly = 0, sel_dly = 0, ph1_dly = 0, conv_dly = 0, wb_dly = 0;
  int checks = 0, failures = 0, pushed = 0, popped = 0;
  bit ld_seen = 0, sel_seen = 0, overlap_seen = 0, running = 1;
  logic [LW:0] expq[$];

  always #2 clk = ~clk;

  vmm_step_ctrl #(.ROWS(ROWS), .COLS(COLS), .LAYER_W(LW)) u_vmm_step_ctrl (.*);

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // driver: issues an operation and pushes the expected writebacks
  task automatic run_op(input int base, input int nlm1, input int rows, input int cols);
    @(negedge clk);
    while (!op_ready) @(negedge clk);
    op_start = 1; op_base = LW'(base); op_nlm1 = LW'(nlm1);
    op_rows = ROWS'(rows); op_cols = COLS'(cols);
    for (int s = 0; s <= nlm1; s++) begin
      expq.push_back({(s == nlm1) ? 1'b1 : 1'b0, LW'(base + s)});
      pushed++;
    end
    @(negedge clk);
    op_start = 0;
    chk(row_en == ROWS'(rows) && col_en == COLS'(cols), "R1 enables latched", int'(row_en), rows);
    chk(!ld_req && !sel_req && !op_ready, "R2 enable-only cycle", int'({ld_req, sel_req, op_ready}), 0);
    @(negedge clk);
    chk(ld_req && sel_req, "R2 load and select together", int'({ld_req, sel_req}), 3);
  endtask

  // responders
  initial forever begin
    @(negedge clk);
    if (ld_req) begin
      if (wb_req) overlap_seen = 1;
      repeat (ld_dly) @(negedge clk);
      ld_done = 1; ld_seen = 1;
      @(negedge clk); ld_done = 0;
    end
  end
  initial forever begin
    @(negedge clk);
    if (sel_req) begin
      repeat (sel_dly) @(negedge clk);
      sel_done = 1; sel_seen = 1;
      @(negedge clk); sel_done = 0;
    end
  end
  initial forever begin
    @(negedge clk);
    if (ph1_req) begin
      chk(ld_seen && sel_seen, "R3 phase I after both fetches", int'({ld_seen, sel_seen}), 3);
      chk(vmm_op && !sweep_sel, "R4 operation mode in phase I", int'({vmm_op, sweep_sel}), 2);
      ld_seen = 0; sel_seen = 0;
      repeat (ph1_dly) @(negedge clk);
      ph1_done = 1;
      @(negedge clk); ph1_done = 0;
    end
  end
  initial forever begin
    @(negedge clk);
    if (conv_req) begin
      chk(sweep_sel && !vmm_op, "R5 sweep layer during conversion", int'({sweep_sel, vmm_op}), 2);
      repeat (conv_dly) @(negedge clk);
      conv_done = 1;
      @(negedge clk); conv_done = 0;
    end
  end
  // monitor / collector: pops the scoreboard on completion
  initial forever begin
    @(negedge clk);
    if (wb_req) begin
      logic [LW:0] e;
      repeat (wb_dly) @(negedge clk);
      if (expq.size() == 0) begin
        chk(0, "R8 unexpected writeback", int'(wb_layer), -1);
      end else begin
        e = expq.pop_front();
        popped++;
        chk(wb_layer == e[LW-1:0], "R9 writeback layer", int'(wb_layer), int'(e[LW-1:0]));
        chk(wb_last == e[LW], "R6 last-step flag", int'(wb_last), int'(e[LW]));
      end
      wb_done = 1;
      @(negedge clk); wb_done = 0;
      chk(!wb_req, "R8 gap after writeback", int'(wb_req), 0);
    end
  end

  task automatic set_dly(input int l, input int s, input int p, input int c, input int w);
    ld_dly = l; sel_dly = s; ph1_dly = p; conv_dly = c; wb_dly = w;
  endtask

  task automatic drain();
    int n = 0;
    while ((expq.size() != 0 || !op_ready || wb_req) && n < 2000) begin
      @(negedge clk); n++;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(op_ready && row_en == 0 && col_en == 0 && !ld_req && !sel_req && !vmm_op &&
        !ph1_req && !sweep_sel && !conv_req && !wb_req, "R11 reset state", int'(op_ready), 1);

    set_dly(2, 5, 3, 2, 1);
    run_op(5, 0, 4'b1010, 8'h3C);
    drain();
    chk(row_en == 0 && col_en == 0, "R1 enables cleared when idle", int'(col_en), 0);

    set_dly(6, 0, 1, 4, 1);
    run_op(10, 3, 4'b1111, 8'hFF);
    drain();

    set_dly(1, 1, 2, 2, 30);
    overlap_seen = 0;
    run_op(20, 2, 4'b0001, 8'h01);
    while (!(wb_req && wb_last)) @(negedge clk);
    chk(op_ready, "R10 idle while last writeback open", int'(op_ready), 1);
    run_op(40, 1, 4'b0110, 8'h81);
    chk(overlap_seen, "R7 next load overlaps writeback", int'(overlap_seen), 1);
    drain();

    set_dly(0, 0, 0, 0, 0);
    run_op(62, 2, 4'b1000, 8'h80);
    drain();

    chk(expq.size() == 0 && pushed == popped, "R9 writeback count", popped, pushed);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    running = 0;
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (running) begin
      checks++; failures++;
      $display("FAIL watchdog R9 actual=%0d expected=%0d", popped, pushed);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule